// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Timer

This block is a clocked pulse stretcher. It drives a single output high for a programmed number of clock cycles once a qualified trigger event occurs. The pulse length is the product of two small unsigned operands. One operand plays the role of a resistance and the other the role of a capacitance, so firmware or neighbouring logic can pick a width without a multiplier of its own.

Three kinds of event arm the timer. A falling edge on an active-low trigger counts only while the active-high trigger sits high. A rising edge on the active-high trigger counts only while the active-low trigger sits low. When the clear input is released, that also counts as a trigger if both trigger inputs are at their enabling levels at that moment.

A trigger that arrives while the pulse is running reloads the full length, which stretches the output. Holding clear low cuts the pulse short and blocks all triggers. All three control inputs are asynchronous and pass through two-flop synchronizers before they are used.

Top module: `retrig_oneshot`

## Requirements
- R1: With `gate_lo_n` low, a rising edge on `gate_hi` drives `pulse` high for exactly `span_r*span_c` cycles. When the input changes just before clock edge k, `pulse` first reads high after edge k+2.
- R2: With `gate_hi` high, a falling edge on `gate_lo_n` starts a pulse with the same width and latency as in R1.
- R3: With `gate_lo_n` low and `gate_hi` high, a rising edge on `arm_n` starts a pulse with the same width and latency as in R1.
- R4: When `arm_n` goes low just before edge k, `pulse` reads low after edge k+1. The running count is discarded. While `arm_n` stays low, edges on either trigger input start nothing.
- R5: No pulse starts when a `gate_hi` rise occurs with `gate_lo_n` high. None starts on a `gate_lo_n` fall with `gate_hi` low, or on an `arm_n` rise with `gate_lo_n` high. `pulse` only ever rises after an accepted trigger.
- R6: An accepted trigger during a pulse reloads the full length. When two rising edges on `gate_hi` are d cycles apart and d is less than the length, the output stays high for d plus the length in one unbroken run.
- R7: The operands are captured when a trigger is accepted. Changing them during a pulse does not alter that pulse.
- R8: When the operand product is zero, a trigger produces no pulse.
- R9: A trigger-input level held for a single clock period is accepted.
- R10: `rst`, sampled at a clock edge, clears the count, so `pulse` reads low and `pulse_n` reads high after that edge. `pulse_n` is always the complement of `pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_lo_n | input | 1 | Trigger input, falling edge active, also enables `gate_hi` when low |
| gate_hi | input | 1 | Trigger input, rising edge active, also enables `gate_lo_n` when high |
| arm_n | input | 1 | Active-low clear; its release can trigger |
| span_r | input | R_W | Resistance-like length operand |
| span_c | input | C_W | Capacitance-like length operand |
| pulse | output | 1 | One-shot output |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The bench sweeps every operand pair of a 3-bit by 3-bit configuration. A multiplier that drops a bit or swaps in a sum would miss the width on some pair, and a missing zero-product guard would emit a stray cycle. Retrigger spacing is chosen so that a design which ignores reloads, or which adds instead of restarting, ends the run at the wrong cycle. A blocked trigger on `gate_hi` is placed during a clear, so a design that forgot to gate triggers with clear would pulse again. The clear release is set up with the enabling levels both present and absent, which catches the wrong polarity in the third trigger path. An operand change mid-pulse catches a design that reads the operands live.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // index of each control input inside the synchronizer bank
  localparam int SIG_LO  = 0;
  localparam int SIG_HI  = 1;
  localparam int SIG_ARM = 2;
  localparam int NUM_SIG = 3;

  // which path accepted a trigger this cycle
  typedef struct packed {
    logic by_arm;
    logic by_lo;
    logic by_hi;
  } trig_src_t;

  function automatic logic any_src(input trig_src_t s);
    return s.by_arm | s.by_lo | s.by_hi;
  endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic lvl,
  output logic lvl_d
);

  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= {STAGES{IDLE}};
      lvl_d <= IDLE;
    end else begin
      sh    <= {sh[STAGES-2:0], d};
      lvl_d <= sh[STAGES-1];
    end
  end

  assign lvl = sh[STAGES-1];

endmodule

// File: rtl/os_trigger_qual.sv
module os_trigger_qual
  import oneshot_pkg::*;
(
  input  logic      lo_lvl,
  input  logic      lo_prev,
  input  logic      hi_lvl,
  input  logic      hi_prev,
  input  logic      arm_lvl,
  input  logic      arm_prev,
  output trig_src_t src
);

  logic lo_fall, hi_rise, arm_rise;

  always_comb begin
    lo_fall  = lo_prev  & ~lo_lvl;
    hi_rise  = hi_lvl   & ~hi_prev;
    arm_rise = arm_lvl  & ~arm_prev;
    src.by_hi  = hi_rise  & ~lo_lvl;
    src.by_lo  = lo_fall  &  hi_lvl;
    src.by_arm = arm_rise & ~lo_lvl & hi_lvl;
  end

endmodule

// File: rtl/os_period_counter.sv
module os_period_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         busy
);

  // priority: reset/clear, then reload, then countdown
  always_ff @(posedge clk) begin
    if (rst || clear)     cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int R_W         = 4,
  parameter int C_W         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           gate_lo_n,
  input  logic           gate_hi,
  input  logic           arm_n,
  input  logic [R_W-1:0] span_r,
  input  logic [C_W-1:0] span_c,
  output logic           pulse,
  output logic           pulse_n
);

  localparam int CNT_W = R_W + C_W;
  // idle levels: active-low trigger high, active-high trigger low, clear released
  localparam logic [NUM_SIG-1:0] IDLE_VEC = 3'b101;

  function automatic logic [CNT_W-1:0] pulse_len(input logic [R_W-1:0] rf,
                                                 input logic [C_W-1:0] cf);
    return CNT_W'(rf) * CNT_W'(cf);
  endfunction

  logic [NUM_SIG-1:0] raw, lvl, prev;
  assign raw[SIG_LO]  = gate_lo_n;
  assign raw[SIG_HI]  = gate_hi;
  assign raw[SIG_ARM] = arm_n;

  for (genvar g = 0; g < NUM_SIG; g++) begin : g_sync
    os_sync #(.STAGES(SYNC_STAGES), .IDLE(IDLE_VEC[g])) u_sync (
      .clk  (clk),
      .rst  (rst),
      .d    (raw[g]),
      .lvl  (lvl[g]),
      .lvl_d(prev[g])
    );
  end

  // named internal events for the checker
  trig_src_t        trig_src;
  logic             clr_ok;
  logic             trig_fire;
  logic [CNT_W-1:0] trig_len;
  logic [CNT_W-1:0] cnt_now;
  logic             busy;

  os_trigger_qual u_qual (
    .lo_lvl  (lvl[SIG_LO]),
    .lo_prev (prev[SIG_LO]),
    .hi_lvl  (lvl[SIG_HI]),
    .hi_prev (prev[SIG_HI]),
    .arm_lvl (lvl[SIG_ARM]),
    .arm_prev(prev[SIG_ARM]),
    .src     (trig_src)
  );

  assign clr_ok    = lvl[SIG_ARM];
  assign trig_fire = clr_ok & any_src(trig_src);
  assign trig_len  = pulse_len(span_r, span_c);

  os_period_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (~clr_ok),
    .load    (trig_fire),
    .load_val(trig_len),
    .cnt     (cnt_now),
    .busy    (busy)
  );

  // clear gates the output the cycle its synchronized level drops
  assign pulse   = busy & clr_ok;
  assign pulse_n = ~pulse;

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             arm_n,
  input logic             pulse,
  input logic             trig_fire,
  input logic [CNT_W-1:0] trig_len,
  input logic [CNT_W-1:0] cnt_now
);

  // R4: clear seen low two edges back forces the output low
  a_r4_clear_forces_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(arm_n, 2)) |-> !pulse);

  // R1: an accepted trigger loads the captured length
  a_r1_fire_loads_len: assert property (@(posedge clk) disable iff (rst)
    trig_fire |=> (cnt_now == $past(trig_len)));

  // R8: zero length keeps the output low
  a_r8_zero_len_quiet: assert property (@(posedge clk) disable iff (rst)
    (trig_fire && trig_len == '0) |=> !pulse);

  // R6: without a reload a running pulse counts down by one
  a_r6_countdown: assert property (@(posedge clk) disable iff (rst)
    (pulse && !trig_fire) |=> (cnt_now == $past(cnt_now) - CNT_W'(1)));

  // R5: the output only rises after an accepted trigger
  a_r5_rise_needs_fire: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(trig_fire));

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .arm_n    (arm_n),
  .pulse    (pulse),
  .trig_fire(trig_fire),
  .trig_len (trig_len),
  .cnt_now  (cnt_now)
);

// File: tb/retrig_oneshot_bench.sv
module retrig_oneshot_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 3;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gate_lo_n = 1'b1;
  logic gate_hi = 1'b0;
  logic arm_n = 1'b1;
  logic [RW-1:0] span_r = '0;
  logic [CW-1:0] span_c = '0;
  logic pulse, pulse_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  retrig_oneshot #(.R_W(RW), .C_W(CW)) u_retrig_oneshot (
    .clk(clk), .rst(rst), .gate_lo_n(gate_lo_n), .gate_hi(gate_hi),
    .arm_n(arm_n), .span_r(span_r), .span_c(span_c),
    .pulse(pulse), .pulse_n(pulse_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // samples the output on the next `window` falling edges
  task automatic measure(input int window, output int onset, output int highs);
    onset = -1;
    highs = 0;
    for (int i = 1; i <= window; i++) begin
      @(negedge clk);
      if (pulse) begin
        highs++;
        if (onset < 0) onset = i;
      end
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int on, hi, hi2, first2;
    idle(4);
    // R10 reset state
    check("R10 reset pulse", int'(pulse), 0);
    check("R10 reset pulse_n", int'(pulse_n), 1);
    rst = 1'b0;
    idle(4);

    // R1 / R8 sweep of every operand pair
    for (int ri = 0; ri < (1 << RW); ri++) begin
      for (int ci = 0; ci < (1 << CW); ci++) begin
        span_r = RW'(ri);
        span_c = CW'(ci);
        gate_lo_n = 1'b0;
        gate_hi = 1'b0;
        idle(3);
        gate_hi = 1'b1;
        measure(60, on, hi);
        if (ri * ci == 0) begin
          check("R8 zero length width", hi, 0);
        end else begin
          check("R1 onset", on, 3);
          check("R1 width", hi, ri * ci);
        end
        gate_hi = 1'b0;
        idle(2);
      end
    end

    // R9 single-cycle trigger level
    span_r = 3'd2; span_c = 3'd3;
    gate_lo_n = 1'b0; gate_hi = 1'b0;
    idle(3);
    gate_hi = 1'b1;
    @(negedge clk);
    gate_hi = 1'b0;
    measure(30, on, hi);
    check("R9 short onset", on, 2);
    check("R9 short width", hi, 6);

    // R5 rise on gate_hi while gate_lo_n high, then R2 fall on gate_lo_n
    gate_lo_n = 1'b1;
    idle(3);
    gate_hi = 1'b1;
    measure(20, on, hi);
    check("R5 hi rise blocked", hi, 0);
    gate_lo_n = 1'b0;
    measure(30, on, hi);
    check("R2 onset", on, 3);
    check("R2 width", hi, 6);

    // R5 fall on gate_lo_n while gate_hi low
    gate_hi = 1'b0; gate_lo_n = 1'b1;
    idle(4);
    gate_lo_n = 1'b0;
    measure(20, on, hi);
    check("R5 lo fall blocked", hi, 0);

    // R6 retrigger five cycles after the first rise, length 12
    span_r = 3'd3; span_c = 3'd4;
    idle(3);
    hi = 0;
    gate_hi = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (pulse) hi++;
      if (i == 2) gate_hi = 1'b0;
      if (i == 5) gate_hi = 1'b1;
    end
    check("R6 stretched width", hi, 17);
    gate_hi = 1'b0;
    idle(3);

    // R7 operand change mid-pulse, captured length 15
    span_r = 3'd3; span_c = 3'd5;
    hi = 0;
    gate_hi = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (pulse) hi++;
      if (i == 6) span_r = 3'd7;
    end
    check("R7 captured width", hi, 15);
    gate_hi = 1'b0;
    idle(3);

    // R4 clear mid-pulse with blocked trigger, then R3 release trigger
    span_r = 3'd2; span_c = 3'd5;
    idle(2);
    hi = 0; hi2 = 0; first2 = -1;
    gate_hi = 1'b1;
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      if (i == 7) check("R4 high before clear", int'(pulse), 1);
      if (i == 8) check("R4 low after clear", int'(pulse), 0);
      if (i >= 8 && i < 30 && pulse) hi++;
      if (i >= 30 && pulse) begin
        hi2++;
        if (first2 < 0) first2 = i;
      end
      if (i == 6)  arm_n = 1'b0;
      if (i == 10) gate_hi = 1'b0;
      if (i == 12) gate_hi = 1'b1;
      if (i == 30) arm_n = 1'b1;
    end
    check("R4 triggers blocked during clear", hi, 0);
    check("R3 release onset", first2, 33);
    check("R3 release width", hi2, 10);
    idle(5);

    // R5 clear release with gate_lo_n high
    gate_lo_n = 1'b1;
    idle(3);
    arm_n = 1'b0;
    idle(4);
    arm_n = 1'b1;
    measure(20, on, hi);
    check("R5 release blocked", hi, 0);

    // R10 reset mid-pulse
    gate_hi = 1'b0;
    idle(2);
    gate_lo_n = 1'b0;
    idle(3);
    gate_hi = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 4) check("R10 running before reset", int'(pulse), 1);
      if (i == 6) begin
        check("R10 reset clears pulse", int'(pulse), 0);
        check("R10 reset pulse_n", int'(pulse_n), 1);
      end
      if (i == 5) begin rst = 1'b1; gate_hi = 1'b0; end
      if (i == 7) rst = 1'b0;
    end
    measure(10, on, hi);
    check("R10 quiet after reset", hi, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule